// File: doc/BRIEF.md
# Two-Wire Line Conditioner and Bus Condition Detector

This block sits between the raw clock and data pins of a two-wire serial bus and the slave protocol engine behind them. Each pin is brought into the system clock domain through a flop chain. It then passes a digital glitch filter, so the filtered level moves only after the synchronised level has disagreed with it for a set number of system clocks. Shorter spikes vanish before event detection, so they can never fake an edge or a bus condition.

From the two filtered levels the block derives single-cycle pulses for clock rising, clock falling, START and STOP. A START seen while a transfer is already open is a repeated START and uses the same pulse. A bus-idle flag is set by STOP and cleared by START. When the engine transmits, it requests the data-line pull-down through an enable input. Every change of that enable is held off for a set number of clocks after each clock falling edge, so the slave's own data never moves while the clock line may still read as high. That prevents false START or STOP conditions.

Top module: `tw_line_frontend`

## Requirements
- R1: During and right after reset, `scl_lvl_o` and `sda_lvl_o` are 1, `bus_idle_o` is 1, `sda_oe_o` is 0 and all four event pulses are 0.
- R2: A level on either raw input that lasts fewer than FILT_CYCLES consecutive system clocks never reaches the filtered level and produces no event pulse.
- R3: A raw level that holds for FILT_CYCLES clocks or more reaches the filtered output. It appears exactly SYNC_STAGES + FILT_CYCLES clock edges after the raw input changed.
- R4: `start_o` pulses for one cycle when the filtered data level falls while the filtered clock level is high in both this and the previous cycle.
- R5: `stop_o` pulses for one cycle when the filtered data level rises while the filtered clock level is high in both this and the previous cycle.
- R6: `scl_rise_o` and `scl_fall_o` pulse for one cycle on each rising or falling change of the filtered clock level. Data changes while the clock is low produce no pulse.
- R7: A START during an open transfer (no STOP since the last START) is signalled on `start_o` with no `stop_o`.
- R8: `bus_idle_o` goes to 0 the cycle after a START pulse and to 1 the cycle after a STOP pulse. Otherwise it keeps its value.
- R9: Any change of the filtered data level while the filtered clock is high in both cycles is reported as START or STOP. At most one of the four event pulses is high in any cycle.
- R10: `sda_oe_o` (1 = pull the data line low) takes the value of `sda_oe_req_i` one clock edge later whenever no hold window is open.
- R11: After a cycle with `scl_fall_o` high, `sda_oe_o` stays frozen for the next HOLD_CYCLES + 1 clock edges. The request present at the next edge after that is applied. A request made at the fall itself therefore shows up HOLD_CYCLES + 2 edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw_i | input | 1 | Raw clock line from the pad |
| sda_raw_i | input | 1 | Raw data line from the pad |
| sda_oe_req_i | input | 1 | Engine request to pull the data line low |
| scl_lvl_o | output | 1 | Filtered clock level |
| sda_lvl_o | output | 1 | Filtered data level |
| start_o | output | 1 | START or repeated START pulse |
| stop_o | output | 1 | STOP pulse |
| scl_rise_o | output | 1 | Filtered clock rising pulse |
| scl_fall_o | output | 1 | Filtered clock falling pulse |
| bus_idle_o | output | 1 | Bus idle flag |
| sda_oe_o | output | 1 | Delayed pull-down enable to the pad |

## Verification
The hardest case to reach is a request change that lands inside the hold window at each possible offset from the clock fall. The fall pulse only appears after the synchroniser and the filter, so its cycle cannot be predicted from the raw stimulus. The bench therefore waits until it sees `scl_fall_o` and then raises the request at each offset from zero to beyond the window end. It measures the edge on which the enable moves against the larger of the window length and the request time. Glitch widths on both lines are swept around the filter threshold, which covers the one-cycle-short case.

// File: rtl/tw_fe_pkg.sv
package tw_fe_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } tw_evt_t;

  localparam int unsigned LANE_SCL = 0;
  localparam int unsigned LANE_SDA = 1;
  localparam int unsigned LANES    = 2;
endpackage

// File: rtl/tw_glitch_filter.sv
module tw_glitch_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   lvl_q, lvl_d;
  logic                   diff, hit, cnt_en;

  // synchroniser chain, idle-high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  always_comb begin
    diff   = sync_q[SYNC_STAGES-1] ^ lvl_q;
    hit    = diff && (cnt_q == CW'(FILT_CYCLES - 1));
    cnt_d  = (!diff || hit) ? '0 : cnt_q + 1'b1;
    lvl_d  = hit ? ~lvl_q : lvl_q;
    cnt_en = diff || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (hit)    lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
  import tw_fe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output tw_evt_t evt_o,
  output logic    idle_o
);
  logic    scl_q, sda_q, idle_q, idle_d;
  tw_evt_t evt;

  always_comb begin
    evt.start = scl_i && scl_q && sda_q && !sda_i;
    evt.stop  = scl_i && scl_q && !sda_q && sda_i;
    evt.rise  = scl_i && !scl_q;
    evt.fall  = !scl_i && scl_q;
    idle_d    = evt.stop ? 1'b1 : (evt.start ? 1'b0 : idle_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      idle_q <= 1'b1;
    end else begin
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      if (evt.start || evt.stop) idle_q <= idle_d;
    end
  end

  assign evt_o  = evt;
  assign idle_o = idle_q;
endmodule

// File: rtl/tw_oe_hold.sv
module tw_oe_hold #(
  parameter int unsigned HOLD_CYCLES = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic req_i,
  output logic oe_o
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          cnt_en, oe_en, oe_q;

  always_comb begin
    cnt_en = fall_i || (cnt_q != '0);
    cnt_d  = fall_i ? HW'(HOLD_CYCLES) : cnt_q - 1'b1;
    oe_en  = (cnt_q == '0) && !fall_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (oe_en)  oe_q  <= req_i;
    end
  end

  assign oe_o = oe_q;
endmodule

// File: rtl/tw_line_frontend.sv
module tw_line_frontend
  import tw_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 7,
  parameter int unsigned HOLD_CYCLES = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw_i,
  input  logic sda_raw_i,
  input  logic sda_oe_req_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic bus_idle_o,
  output logic sda_oe_o
);
  logic [LANES-1:0] raw_vec, lvl_vec;
  tw_evt_t          evt;

  assign raw_vec[LANE_SCL] = scl_raw_i;
  assign raw_vec[LANE_SDA] = sda_raw_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tw_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_vec[g]),
      .lvl_o (lvl_vec[g])
    );
  end

  tw_cond_detect u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (lvl_vec[LANE_SCL]),
    .sda_i  (lvl_vec[LANE_SDA]),
    .evt_o  (evt),
    .idle_o (bus_idle_o)
  );

  tw_oe_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .fall_i (evt.fall),
    .req_i  (sda_oe_req_i),
    .oe_o   (sda_oe_o)
  );

  assign scl_lvl_o  = lvl_vec[LANE_SCL];
  assign sda_lvl_o  = lvl_vec[LANE_SDA];
  assign start_o    = evt.start;
  assign stop_o     = evt.stop;
  assign scl_rise_o = evt.rise;
  assign scl_fall_o = evt.fall;
endmodule

// File: rtl/tw_line_frontend_chk.sv
module tw_line_frontend_chk #(
  parameter int unsigned HOLD_CYCLES = 38
) (
  input logic clk,
  input logic rst_n,
  input logic sda_oe_req_i,
  input logic scl_lvl_o,
  input logic sda_lvl_o,
  input logic start_o,
  input logic stop_o,
  input logic scl_rise_o,
  input logic scl_fall_o,
  input logic bus_idle_o,
  input logic sda_oe_o
);
  localparam int unsigned WW = $clog2(HOLD_CYCLES + 2);
  logic [WW-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win_q <= '0;
    else if (scl_fall_o) win_q <= WW'(HOLD_CYCLES + 1);
    else if (win_q != 0) win_q <= win_q - 1'b1;
  end

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !bus_idle_o);
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> bus_idle_o);
  p_evt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));
  p_sda_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl_o && $past(scl_lvl_o) && (sda_lvl_o != $past(sda_lvl_o)))
      |-> (start_o || stop_o));
  p_oe_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != 0) |-> $stable(sda_oe_o));
  p_oe_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == 0 && !scl_fall_o) |=> (sda_oe_o == $past(sda_oe_req_i)));
endmodule

bind tw_line_frontend tw_line_frontend_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sda_oe_req_i (sda_oe_req_i),
  .scl_lvl_o    (scl_lvl_o),
  .sda_lvl_o    (sda_lvl_o),
  .start_o      (start_o),
  .stop_o       (stop_o),
  .scl_rise_o   (scl_rise_o),
  .scl_fall_o   (scl_fall_o),
  .bus_idle_o   (bus_idle_o),
  .sda_oe_o     (sda_oe_o)
);

// File: tb/test_tw_line_frontend.sv
module test_tw_line_frontend;
  localparam int SYNC = 2;
  localparam int FILT = 4;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_raw = 1'b1, sda_raw = 1'b1, oe_req = 1'b0;
  logic scl_lvl, sda_lvl, start_p, stop_p, rise_p, fall_p, idle, oe;

  int n_chk = 0, n_bad = 0;
  int c_start = 0, c_stop = 0, c_rise = 0, c_fall = 0;

  always #4 clk = ~clk;

  tw_line_frontend #(.SYNC_STAGES(SYNC), .FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD)) i_tw_line_frontend (
    .clk(clk), .rst_n(rst_n), .scl_raw_i(scl_raw), .sda_raw_i(sda_raw),
    .sda_oe_req_i(oe_req), .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
    .start_o(start_p), .stop_o(stop_p), .scl_rise_o(rise_p), .scl_fall_o(fall_p),
    .bus_idle_o(idle), .sda_oe_o(oe));

  always @(negedge clk) if (rst_n) begin
    c_start += int'(start_p);
    c_stop  += int'(stop_p);
    c_rise  += int'(rise_p);
    c_fall  += int'(fall_p);
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    tick(FILT + SYNC + 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s0, p0, r0, f0, k, exp_k;
    tick(3);
    // R1 reset state
    check("R1 scl_lvl", int'(scl_lvl), 1);
    check("R1 sda_lvl", int'(sda_lvl), 1);
    check("R1 idle", int'(idle), 1);
    check("R1 oe", int'(oe), 0);
    check("R1 pulses", int'({start_p, stop_p, rise_p, fall_p}), 0);
    rst_n = 1'b1;
    tick(4);
    check("R1 after release", int'({scl_lvl, sda_lvl, idle, oe}), 4'b1110);

    // R2 / R3 / R6 glitch sweep on clock line
    for (int w = 1; w <= FILT + 2; w++) begin
      r0 = c_rise; f0 = c_fall; s0 = c_start; p0 = c_stop;
      scl_raw = 1'b0; tick(w); scl_raw = 1'b1; settle();
      check($sformatf("R2/R6 scl w=%0d rise", w), c_rise - r0, (w >= FILT) ? 1 : 0);
      check($sformatf("R2/R6 scl w=%0d fall", w), c_fall - f0, (w >= FILT) ? 1 : 0);
      check($sformatf("R2 scl w=%0d cond", w), (c_start - s0) + (c_stop - p0), 0);
    end
    // R2 / R4 / R5 glitch sweep on data line with clock high
    for (int w = 1; w <= FILT + 2; w++) begin
      s0 = c_start; p0 = c_stop;
      sda_raw = 1'b0; tick(w); sda_raw = 1'b1; settle();
      check($sformatf("R2/R4 sda w=%0d start", w), c_start - s0, (w >= FILT) ? 1 : 0);
      check($sformatf("R2/R5 sda w=%0d stop", w), c_stop - p0, (w >= FILT) ? 1 : 0);
      check($sformatf("R8 sda w=%0d idle", w), int'(idle), 1);
    end

    // R3 latency, clock line
    scl_raw = 1'b0; k = 0;
    while (scl_lvl && k < 50) begin tick(1); k++; end
    check("R3 latency", k, SYNC + FILT);
    scl_raw = 1'b1; settle();

    // full transfer: START, data, repeated START, STOP
    s0 = c_start; p0 = c_stop;
    sda_raw = 1'b0; settle();
    check("R4 start", c_start - s0, 1);
    check("R8 busy", int'(idle), 0);
    scl_raw = 1'b0; settle();
    sda_raw = 1'b1; settle(); sda_raw = 1'b0; settle(); sda_raw = 1'b1; settle();
    check("R6 data low no cond", (c_start - s0) + (c_stop - p0), 1);
    scl_raw = 1'b1; settle();
    sda_raw = 1'b0; settle();
    check("R7 repeated start", c_start - s0, 2);
    check("R7 no stop", c_stop - p0, 0);
    check("R7 busy", int'(idle), 0);
    scl_raw = 1'b0; settle(); scl_raw = 1'b1; settle();
    sda_raw = 1'b1; settle();
    check("R5 stop", c_stop - p0, 1);
    check("R8 idle", int'(idle), 1);

    // R10 direct follow
    oe_req = 1'b1; tick(1);
    check("R10 follow high", int'(oe), 1);
    oe_req = 1'b0; tick(1);
    check("R10 follow low", int'(oe), 0);

    // R11 hold window sweep
    for (int d = 0; d <= HOLD + 4; d++) begin
      oe_req = 1'b0; scl_raw = 1'b1; tick(HOLD + 4); settle();
      scl_raw = 1'b0; k = 0;
      while (!fall_p && k < 50) begin tick(1); k++; end
      k = 0;
      if (d == 0) oe_req = 1'b1;
      while (!oe && k < 60) begin
        tick(1); k++;
        if (!oe && k == d) oe_req = 1'b1;
      end
      exp_k = (d + 1 > HOLD + 2) ? d + 1 : HOLD + 2;
      check($sformatf("R11 delay d=%0d", d), k, exp_k);
    end
    oe_req = 1'b0; scl_raw = 1'b1; tick(HOLD + 4); settle();
    check("R10 release", int'(oe), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule